// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block moves bytes between a parallel handshake interface and a serial PCM-style line whose bit clock and frame sync come from outside. It runs entirely on a fast system clock. The external bit clock, the frame-sync input and the serial receive input all pass through a multi-flop synchronizer. Rising and falling bit-clock edges are then found by comparing successive synchronized samples. Transmit bits are launched after bit-clock rising edges. Receive bits are captured on bit-clock falling edges.

Two framing modes are available. In the short mode, a one-bit sync pulse comes before the data. In the long mode, sync envelopes the data field. The mode is taken from an input while no frame is in progress. Outside the data window the transmit-enable output is low, so the serial pin can float. Single-cycle error pulses report four conditions: underrun, overrun, a short-mode sync that comes too early, and a long-mode frame cut short.

Top module: `pcm_port`

## Requirements
- R1: After reset, `txd_oe_o` is 0, `txd_o` is 1, `tx_ready_o` is 1, `rx_valid_o` is 0 and no error output pulses.
- R2: Short mode (`mode_long_i`=0): a bit-clock rising edge that samples sync high arms a frame. The 8 data bits, most significant first, are launched one per rising edge, starting at the next rising edge.
- R3: Long mode (`mode_long_i`=1): from idle, the first rising edge that samples sync high launches the most significant bit. The remaining 7 bits follow on the next rising edges while sync stays high.
- R4: Receive bits are captured on bit-clock falling edges during the data window, most significant first. After the 8th capture, `rx_data_o` holds the byte and `rx_valid_o` is 1. `rx_valid_o` stays 1 until a cycle with `rx_ready_i`=1.
- R5: `txd_oe_o` is 1 exactly for the data bit periods. It drops after the rising edge that follows the 8th bit. While it is 0, `txd_o` is 1.
- R6: Short mode: a sync sampled fewer than 8 rising edges after the last accepted sync pulses `err_gap_o` and is otherwise ignored. A sync exactly 8 edges later is accepted, and its frame follows the previous one with no gap.
- R7: If no byte is held when a frame starts, the frame sends 8'hFF and `err_underrun_o` pulses once.
- R8: If a new received byte completes while `rx_valid_o`=1 and `rx_ready_i`=0, `err_overrun_o` pulses once and the new byte replaces the old.
- R9: Long mode: if sync is sampled low at a rising edge before all 8 bits have been launched, the frame ends. `txd_oe_o` drops, `err_abort_o` pulses once and no byte is delivered.
- R10: Long mode: if sync stays high beyond the 8 bits, no further frame starts until a rising edge samples sync low.
- R11: The mode input is sampled only while no frame is armed or active. A change during a frame does not affect that frame.
- R12: `tx_ready_o` is 1 while the one-byte transmit holder is empty. An accepted byte makes it 0 until a frame start takes the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, more than 2.5x the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_i | input | 1 | External bit clock |
| fsync_i | input | 1 | External frame sync |
| rxd_i | input | 1 | Serial receive data |
| mode_long_i | input | 1 | 0 short-frame, 1 long-frame |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Transmit holder empty |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | Received byte waiting |
| rx_ready_i | input | 1 | Received byte taken |
| txd_o | output | 1 | Serial transmit data |
| txd_oe_o | output | 1 | Transmit driver enable |
| err_underrun_o | output | 1 | Pulse: frame started with no byte |
| err_overrun_o | output | 1 | Pulse: received byte overwritten |
| err_gap_o | output | 1 | Pulse: short-mode sync too early |
| err_abort_o | output | 1 | Pulse: long-mode frame cut short |

## Verification
The bench builds the port with its defaults: 8-bit words, a minimum sync distance of 8, and two synchronizer stages. It drives the bit clock at one eighth of the system clock, which leaves room to sample the line halfway through each bit period despite the synchronizer latency. With these values the 7-versus-8 sync distance boundary fits in one short capture window. Back-to-back short frames, long sync held past the word, and an abort after 4 bits can each be observed period by period.

// File: rtl/pcm_pkg.sv
// Shared types for the PCM serial port.
package pcm_pkg;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_DATA = 2'd1,
        FR_HOLD = 2'd2
    } frame_state_t;

    typedef enum logic {
        SYNC_SHORT = 1'b0,
        SYNC_LONG  = 1'b1
    } sync_mode_t;

    // Commands from the frame controller to the shifter, one cycle wide.
    typedef struct packed {
        logic start;    // load a word and launch its first bit
        logic shift;    // launch the next bit
        logic stop;     // close the data window
        logic rx_samp;  // capture one receive bit
        logic rx_last;  // this capture completes the word
    } pcm_cmd_t;

endpackage

// File: rtl/pcm_sync.sv
// Multi-stage synchronizer for a bus of asynchronous single-bit inputs.
// Assumes each bit is independent; no bus coherency is implied.
module pcm_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one flop stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[g] <= '0;
                end else if (g == 0) begin
                    stg[g] <= din;
                end else begin
                    stg[g] <= stg[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/pcm_edge_det.sv
// Edge detector on a synchronized level. Produces one-cycle rise and fall
// pulses. Assumes the level stays stable for at least two cycles.
module pcm_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    // Purpose: remember the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/pcm_frame_ctrl.sv
// Frame controller: sequences the data window from bit-clock edge pulses and
// the synchronized sync level, for both sync modes. It checks the minimum
// sync spacing in short mode and flags sync loss in long mode.
// Assumes rise and fall pulses never occur in the same cycle.
module pcm_frame_ctrl
    import pcm_pkg::*;
#(
    parameter int WORD_BITS = 8,
    parameter int GAP_MIN   = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rise_i,
    input  logic     fall_i,
    input  logic     sync_i,
    input  logic     mode_long_i,
    output pcm_cmd_t cmd_o,
    output logic     err_gap_o,
    output logic     err_abort_o
);
    localparam int CNT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
    localparam int GAP_W = $clog2(GAP_MIN + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);
    localparam logic [GAP_W-1:0] GAP_SAT  = GAP_W'(GAP_MIN);

    frame_state_t     state_q;
    sync_mode_t       mode_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [GAP_W-1:0] since_q;
    logic             pend_q;
    logic             samp_due_q;

    // Purpose: frame sequencing, sync checks and command generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FR_IDLE;
            mode_q      <= SYNC_SHORT;
            bit_cnt_q   <= '0;
            since_q     <= GAP_SAT;
            pend_q      <= 1'b0;
            samp_due_q  <= 1'b0;
            cmd_o       <= '0;
            err_gap_o   <= 1'b0;
            err_abort_o <= 1'b0;
        end else begin
            cmd_o       <= '0;
            err_gap_o   <= 1'b0;
            err_abort_o <= 1'b0;

            if (state_q == FR_IDLE && !pend_q) begin
                mode_q <= sync_mode_t'(mode_long_i);
            end

            if (fall_i && samp_due_q) begin
                cmd_o.rx_samp <= 1'b1;
                cmd_o.rx_last <= (bit_cnt_q == LAST_BIT);
                samp_due_q    <= 1'b0;
            end

            if (rise_i) begin
                if (mode_q == SYNC_SHORT) begin
                    // data window sequencing
                    case (state_q)
                        FR_IDLE: begin
                            if (pend_q) begin
                                cmd_o.start <= 1'b1;
                                bit_cnt_q   <= '0;
                                samp_due_q  <= 1'b1;
                                pend_q      <= 1'b0;
                                state_q     <= FR_DATA;
                            end
                        end
                        FR_DATA: begin
                            if (bit_cnt_q == LAST_BIT) begin
                                if (pend_q) begin
                                    cmd_o.start <= 1'b1;
                                    bit_cnt_q   <= '0;
                                    samp_due_q  <= 1'b1;
                                    pend_q      <= 1'b0;
                                end else begin
                                    cmd_o.stop <= 1'b1;
                                    samp_due_q <= 1'b0;
                                    state_q    <= FR_IDLE;
                                end
                            end else begin
                                cmd_o.shift <= 1'b1;
                                bit_cnt_q   <= bit_cnt_q + 1'b1;
                                samp_due_q  <= 1'b1;
                            end
                        end
                        default: state_q <= FR_IDLE;
                    endcase
                    // sync spacing check; an accepted sync arms the next frame
                    if (sync_i && since_q >= GAP_SAT) begin
                        pend_q  <= 1'b1;
                        since_q <= GAP_W'(1);
                    end else begin
                        if (sync_i) err_gap_o <= 1'b1;
                        if (since_q < GAP_SAT) since_q <= since_q + 1'b1;
                    end
                end else begin
                    case (state_q)
                        FR_IDLE: begin
                            if (sync_i) begin
                                cmd_o.start <= 1'b1;
                                bit_cnt_q   <= '0;
                                samp_due_q  <= 1'b1;
                                state_q     <= FR_DATA;
                            end
                        end
                        FR_DATA: begin
                            if (bit_cnt_q == LAST_BIT) begin
                                cmd_o.stop <= 1'b1;
                                samp_due_q <= 1'b0;
                                state_q    <= sync_i ? FR_HOLD : FR_IDLE;
                            end else if (!sync_i) begin
                                cmd_o.stop  <= 1'b1;
                                samp_due_q  <= 1'b0;
                                err_abort_o <= 1'b1;
                                state_q     <= FR_IDLE;
                            end else begin
                                cmd_o.shift <= 1'b1;
                                bit_cnt_q   <= bit_cnt_q + 1'b1;
                                samp_due_q  <= 1'b1;
                            end
                        end
                        FR_HOLD: begin
                            if (!sync_i) state_q <= FR_IDLE;
                        end
                        default: state_q <= FR_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/pcm_shifter.sv
// Data path: a one-word transmit holder with a valid/ready handshake, a
// transmit shift register with its output enable, and a receive shift
// register with a one-word output buffer. It acts only on controller commands.
module pcm_shifter
    import pcm_pkg::*;
#(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  pcm_cmd_t             cmd_i,
    input  logic                 rxd_i,
    input  logic [WORD_BITS-1:0] tx_data_i,
    input  logic                 tx_valid_i,
    output logic                 tx_ready_o,
    output logic [WORD_BITS-1:0] rx_data_o,
    output logic                 rx_valid_o,
    input  logic                 rx_ready_i,
    output logic                 txd_o,
    output logic                 txd_oe_o,
    output logic                 err_underrun_o,
    output logic                 err_overrun_o
);
    localparam logic [WORD_BITS-1:0] IDLE_WORD = '1;

    logic [WORD_BITS-1:0] hold_q;
    logic                 hold_full_q;
    logic [WORD_BITS-1:0] tx_sh_q;
    logic                 oe_q;
    logic [WORD_BITS-1:0] rx_sh_q;
    logic [WORD_BITS-1:0] rx_next;

    assign tx_ready_o = ~hold_full_q;
    assign rx_next    = {rx_sh_q[WORD_BITS-2:0], rxd_i};
    assign txd_o      = oe_q ? tx_sh_q[WORD_BITS-1] : 1'b1;
    assign txd_oe_o   = oe_q;

    // Purpose: transmit holder, shift register and output enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q         <= '0;
            hold_full_q    <= 1'b0;
            tx_sh_q        <= IDLE_WORD;
            oe_q           <= 1'b0;
            err_underrun_o <= 1'b0;
        end else begin
            err_underrun_o <= 1'b0;
            if (cmd_i.start) begin
                oe_q <= 1'b1;
                if (hold_full_q) begin
                    tx_sh_q     <= hold_q;
                    hold_full_q <= 1'b0;
                end else begin
                    tx_sh_q        <= IDLE_WORD;
                    err_underrun_o <= 1'b1;
                end
            end else if (cmd_i.shift) begin
                tx_sh_q <= {tx_sh_q[WORD_BITS-2:0], 1'b1};
            end
            if (cmd_i.stop) oe_q <= 1'b0;
            if (tx_valid_i && !hold_full_q) begin
                hold_q      <= tx_data_i;
                hold_full_q <= 1'b1;
            end
        end
    end

    // Purpose: receive shift register, output buffer and overrun detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh_q       <= '0;
            rx_data_o     <= '0;
            rx_valid_o    <= 1'b0;
            err_overrun_o <= 1'b0;
        end else begin
            err_overrun_o <= 1'b0;
            if (cmd_i.rx_samp) rx_sh_q <= rx_next;
            if (cmd_i.rx_samp && cmd_i.rx_last) begin
                rx_data_o     <= rx_next;
                rx_valid_o    <= 1'b1;
                err_overrun_o <= rx_valid_o && !rx_ready_i;
            end else if (rx_valid_o && rx_ready_i) begin
                rx_valid_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcm_port.sv
// PCM serial port top. Synchronizes the bit clock, sync and receive data into
// the system clock domain, detects bit-clock edges and connects the frame
// controller to the data path. Assumes the system clock is more than 2.5
// times the bit clock.
module pcm_port #(
    parameter int WORD_BITS   = 8,
    parameter int GAP_MIN     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk_i,
    input  logic                 fsync_i,
    input  logic                 rxd_i,
    input  logic                 mode_long_i,
    input  logic [WORD_BITS-1:0] tx_data_i,
    input  logic                 tx_valid_i,
    output logic                 tx_ready_o,
    output logic [WORD_BITS-1:0] rx_data_o,
    output logic                 rx_valid_o,
    input  logic                 rx_ready_i,
    output logic                 txd_o,
    output logic                 txd_oe_o,
    output logic                 err_underrun_o,
    output logic                 err_overrun_o,
    output logic                 err_gap_o,
    output logic                 err_abort_o
);
    import pcm_pkg::*;

    localparam int IN_W = 3;

    logic [IN_W-1:0] in_s;
    logic            bclk_rise;
    logic            bclk_fall;
    pcm_cmd_t        cmd;

    pcm_sync #(.N(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({rxd_i, fsync_i, bclk_i}),
        .dout (in_s)
    );

    pcm_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (in_s[0]),
        .rise_o(bclk_rise),
        .fall_o(bclk_fall)
    );

    pcm_frame_ctrl #(.WORD_BITS(WORD_BITS), .GAP_MIN(GAP_MIN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (bclk_rise),
        .fall_i     (bclk_fall),
        .sync_i     (in_s[1]),
        .mode_long_i(mode_long_i),
        .cmd_o      (cmd),
        .err_gap_o  (err_gap_o),
        .err_abort_o(err_abort_o)
    );

    pcm_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_i         (cmd),
        .rxd_i         (in_s[2]),
        .tx_data_i     (tx_data_i),
        .tx_valid_i    (tx_valid_i),
        .tx_ready_o    (tx_ready_o),
        .rx_data_o     (rx_data_o),
        .rx_valid_o    (rx_valid_o),
        .rx_ready_i    (rx_ready_i),
        .txd_o         (txd_o),
        .txd_oe_o      (txd_oe_o),
        .err_underrun_o(err_underrun_o),
        .err_overrun_o (err_overrun_o)
    );
endmodule

// File: rtl/pcm_port_chk.sv
// Checker for pcm_port: temporal properties across the port and the
// bit-clock edge detector. Attached by the bind below.
module pcm_port_chk (
    input logic clk,
    input logic rst_n,
    input logic bclk_rise,
    input logic tx_valid_i,
    input logic tx_ready_o,
    input logic rx_valid_o,
    input logic rx_ready_i,
    input logic txd_o,
    input logic txd_oe_o,
    input logic err_underrun_o,
    input logic err_overrun_o,
    input logic err_gap_o,
    input logic err_abort_o
);
    AST_TX_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_i && tx_ready_o |=> !tx_ready_o); // R12
    AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o && !rx_ready_i |=> rx_valid_o); // R4
    AST_OE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(txd_oe_o) |-> $past(bclk_rise, 2)); // R5
    AST_TXD_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(txd_o) |-> $past(bclk_rise, 2)); // R2
    AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        err_abort_o |=> !txd_oe_o); // R9
    AST_UNDERRUN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        err_underrun_o |-> txd_oe_o && txd_o); // R7
    AST_OVERRUN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun_o |-> rx_valid_o); // R8
    AST_GAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_gap_o |=> !err_gap_o); // R6
endmodule

bind pcm_port pcm_port_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bclk_rise     (bclk_rise),
    .tx_valid_i    (tx_valid_i),
    .tx_ready_o    (tx_ready_o),
    .rx_valid_o    (rx_valid_o),
    .rx_ready_i    (rx_ready_i),
    .txd_o         (txd_o),
    .txd_oe_o      (txd_oe_o),
    .err_underrun_o(err_underrun_o),
    .err_overrun_o (err_overrun_o),
    .err_gap_o     (err_gap_o),
    .err_abort_o   (err_abort_o)
);

// File: tb/tb_pcm_port.sv
module tb_pcm_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;   // bit-clock half period in system clocks
    localparam int NVEC       = 6;
    // vector: {long mode, byte sent, byte received}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'hA5, 8'h3C}, {1'b0, 8'h00, 8'hFF}, {1'b0, 8'h81, 8'h7E},
        {1'b1, 8'hC3, 8'h5A}, {1'b1, 8'hFF, 8'h00}, {1'b1, 8'h12, 8'hE7}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0, fsync = 1'b0, rxd = 1'b0, mode_long = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0, rx_ready = 1'b0;
    logic       tx_ready, rx_valid, txd, txd_oe;
    logic [7:0] rx_data;
    logic       e_under, e_over, e_gap, e_abort;

    int n_chk = 0, n_fail = 0;
    int c_under = 0, c_over = 0, c_gap = 0, c_abort = 0;
    int b_under, b_over, b_gap, b_abort;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_port dut (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .rxd_i(rxd),
        .mode_long_i(mode_long), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
        .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
        .rx_ready_i(rx_ready), .txd_o(txd), .txd_oe_o(txd_oe),
        .err_underrun_o(e_under), .err_overrun_o(e_over),
        .err_gap_o(e_gap), .err_abort_o(e_abort)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (e_under) c_under++;
            if (e_over)  c_over++;
            if (e_gap)   c_gap++;
            if (e_abort) c_abort++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic snap();
        b_under = c_under; b_over = c_over; b_gap = c_gap; b_abort = c_abort;
    endtask

    function automatic logic [31:0] spread(input logic [7:0] b, input int off);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 8; i++) r[off+i] = b[7-i];
        return r;
    endfunction

    function automatic logic [7:0] gather(input logic [31:0] v, input int off);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7-i] = v[off+i];
        return b;
    endfunction

    // One bit period per index: drive sync and rxd at the rising edge,
    // sample the line two system clocks after the falling edge.
    task automatic run_seq(input logic [31:0] sp, input logic [31:0] rp, input int n,
                           output logic [31:0] tc, output logic [31:0] oc);
        tc = '0; oc = '0;
        for (int i = 0; i < n; i++) begin
            bclk = 1'b1; fsync = sp[i]; rxd = rp[i];
            repeat (HALF) @(negedge clk);
            bclk = 1'b0;
            repeat (2) @(negedge clk);
            tc[i] = txd; oc[i] = txd_oe;
            repeat (HALF - 2) @(negedge clk);
        end
        fsync = 1'b0;
    endtask

    task automatic send_tx(input logic [7:0] b);
        tx_data = b; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_rx();
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] tc, oc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 oe", txd_oe, 0);
        chk("R1 txd", txd, 1);
        chk("R1 tx_ready", tx_ready, 1);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 errors", c_under + c_over + c_gap + c_abort, 0);

        // Table walk: one frame per vector
        for (int v = 0; v < NVEC; v++) begin
            mode_long = VEC[v][16];
            snap();
            send_tx(VEC[v][15:8]);
            chk("R12 tx_ready after accept", tx_ready, 0);
            if (!VEC[v][16]) begin
                run_seq(32'h1, spread(VEC[v][7:0], 1), 10, tc, oc);
                chk("R2 short tx byte", gather(tc, 1), VEC[v][15:8]);
                chk("R5 short window", oc, 32'h1FE);
            end else begin
                run_seq(32'hFF, spread(VEC[v][7:0], 0), 9, tc, oc);
                chk("R3 long tx byte", gather(tc, 0), VEC[v][15:8]);
                chk("R5 long window", oc, 32'hFF);
            end
            chk("R4 rx_valid", rx_valid, 1);
            chk("R4 rx_data", rx_data, VEC[v][7:0]);
            chk("R12 tx_ready after start", tx_ready, 1);
            chk("R7 no error", (c_under - b_under) + (c_gap - b_gap) + (c_abort - b_abort), 0);
            repeat (3) @(negedge clk);
            chk("R4 rx held unread", rx_valid, 1);
            read_rx();
            chk("R4 rx cleared by read", rx_valid, 0);
        end

        // R7 underrun
        mode_long = 1'b0;
        snap();
        run_seq(32'h1, spread(8'h00, 1), 10, tc, oc);
        chk("R7 ones sent", gather(tc, 1), 8'hFF);
        chk("R7 underrun pulse", c_under - b_under, 1);
        read_rx();

        // R8 overrun
        snap();
        send_tx(8'h11);
        run_seq(32'h1, spread(8'hAA, 1), 10, tc, oc);
        send_tx(8'h22);
        run_seq(32'h1, spread(8'h55, 1), 10, tc, oc);
        chk("R8 overrun pulse", c_over - b_over, 1);
        chk("R8 newer byte kept", rx_data, 8'h55);
        read_rx();

        // R6 early sync at distance 7
        snap();
        send_tx(8'h96);
        run_seq(32'h81, spread(8'h0F, 1), 10, tc, oc);
        chk("R6 early sync flagged", c_gap - b_gap, 1);
        chk("R6 frame unaffected", gather(tc, 1), 8'h96);
        chk("R6 window unaffected", oc, 32'h1FE);
        read_rx();

        // R6 back-to-back at distance 8
        snap();
        send_tx(8'h3A);
        run_seq(32'h101, spread(8'hC5, 1) | spread(8'h6B, 9), 19, tc, oc);
        chk("R6 distance 8 accepted", c_gap - b_gap, 0);
        chk("R6 contiguous window", oc, 32'h1FFFE);
        chk("R6 first byte", gather(tc, 1), 8'h3A);
        chk("R7 second frame underrun", gather(tc, 9), 8'hFF);
        chk("R8 second byte", rx_data, 8'h6B);
        read_rx();

        // R9 long abort after 4 bits
        mode_long = 1'b1;
        snap();
        send_tx(8'hE1);
        run_seq(32'hF, spread(8'hA5, 0), 6, tc, oc);
        chk("R9 window closes", oc, 32'hF);
        chk("R9 abort pulse", c_abort - b_abort, 1);
        chk("R9 no byte delivered", rx_valid, 0);

        // R10 sync held past the word
        snap();
        send_tx(8'h5C);
        run_seq(32'hFFF, spread(8'h93, 0), 14, tc, oc);
        chk("R10 single window", oc, 32'hFF);
        chk("R10 byte sent", gather(tc, 0), 8'h5C);
        chk("R10 no abort", c_abort - b_abort, 0);
        chk("R10 no underrun", c_under - b_under, 0);
        chk("R10 rx byte", rx_data, 8'h93);
        read_rx();

        // R11 mode change after a short frame is armed
        mode_long = 1'b0;
        repeat (2) @(negedge clk);
        snap();
        send_tx(8'hB4);
        run_seq(32'h1, 32'h0, 1, tc, oc);
        mode_long = 1'b1;
        run_seq(32'h0, spread(8'h2D, 0), 9, tc, oc);
        chk("R11 frame kept short mode", oc, 32'hFF);
        chk("R11 tx byte", gather(tc, 0), 8'hB4);
        chk("R11 rx byte", rx_data, 8'h2D);
        chk("R11 no abort", c_abort - b_abort, 0);
        read_rx();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule